// File: doc/BRIEF.md
# Video Standard Hunt Sequencer

This block produces a 2-bit code that tells an external serial video receiver which data rate to try. While the carrier is present and no line timing has been found, each pulse on the dwell tick input moves the code on by one. It cycles through all four settings until the correct rate is in use. The tick stands in for the analog timing network that would otherwise set the dwell period.

Two separate conditions stop the code from moving: the carrier being absent, or a confirmed timing reference (TRS) reporting that the receiver is locked. In both cases the code keeps its current value instead of clearing, so a locked receiver stays on the rate that works. A lock is given up again when a programmable number of dwell ticks pass with no further TRS report, and hunting then resumes from the held code. Both status inputs are asynchronous and go through two-stage synchronisers before use.

Top module: `std_hunt_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the select code is 0.
- R2: With the carrier present and no lock, each dwell tick raises the select code by one on the following rising edge. The code is binary with bit 1 as MSB and wraps from 3 to 0.
- R3: With no dwell tick, the select code does not change.
- R4: While the carrier is absent, ticks leave the select code at its current value; it is not cleared.
- R5: A TRS report sets lock. While locked, or in a cycle where the synchronised TRS is high, ticks do not move the code.
- R6: A lock is released by the L-th consecutive tick with no TRS report, where L is the limit input. A limit of 0 acts as 1. The releasing tick does not step the code; later ticks do.
- R7: A TRS report during a lock restarts the count of missed ticks.
- R8: Carrier and TRS each pass through two flip-flops. A change first affects ticks sampled on the third rising edge after it; ticks on the first two edges use the old value.
- R9: Missed ticks are counted toward release even while the carrier is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Dwell tick, one cycle per hunt step (synchronous) |
| carrier_i | input | 1 | Carrier present, asynchronous, active high |
| trs_valid_i | input | 1 | Valid timing reference seen, asynchronous, active high |
| miss_limit_i | input | MISS_W | Missed ticks before a lock is dropped (0 acts as 1) |
| sel_o | output | 2 | Standard-select code to the receiver |

## Verification
A tick sampled on a rising edge changes the select code at that same edge, so the bench raises the tick at a falling edge and reads the code at the next falling edge. Carrier and TRS changes need three rising edges before they gate the counter. The bench waits at least four cycles after such a change before it ticks, except in the R8 cases. Those cases tick on the first three edges and expect a step count that shows exactly the two-edge delay. Expected codes are computed modulo 4 from the number of ticks that should count, and release is computed as max(0, k - L) steps after k ticks.

// File: rtl/std_hunt_pkg.sv
`timescale 1ns/1ps
package std_hunt_pkg;

    localparam int SEL_W = 2;

    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic {
        LK_HUNT = 1'b0,
        LK_HOLD = 1'b1
    } lock_state_e;

endpackage

// File: rtl/std_hunt_sync.sv
`timescale 1ns/1ps
module std_hunt_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/std_hunt_lock.sv
`timescale 1ns/1ps
module std_hunt_lock
    import std_hunt_pkg::*;
#(
    parameter int MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              trs_s_i,
    input  logic [MISS_W-1:0] limit_i,
    output logic              locked_o
);

    typedef struct packed {
        lock_state_e       st;
        logic [MISS_W-1:0] miss;
    } lock_reg_t;

    lock_reg_t         lk_d, lk_q;
    logic [MISS_W-1:0] lim_eff;

    always_comb begin
        lim_eff = (limit_i == '0) ? MISS_W'(1) : limit_i;
        lk_d    = lk_q;
        if (trs_s_i) begin
            lk_d.st   = LK_HOLD;
            lk_d.miss = '0;
        end else if (lk_q.st == LK_HOLD && tick_i) begin
            if (lk_q.miss >= lim_eff - MISS_W'(1)) begin
                lk_d.st   = LK_HUNT;
                lk_d.miss = '0;
            end else begin
                lk_d.miss = lk_q.miss + MISS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '{st: LK_HUNT, miss: '0};
        else        lk_q <= lk_d;
    end

    assign locked_o = (lk_q.st == LK_HOLD);

    // R5
    trs_sets_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trs_s_i |=> locked_o);

    // R6
    release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_o) |-> ($past(tick_i) && !$past(trs_s_i)));

endmodule

// File: rtl/std_hunt_count.sv
`timescale 1ns/1ps
module std_hunt_count
    import std_hunt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic carrier_s_i,
    input  logic locked_i,
    input  logic trs_s_i,
    output sel_t sel_o
);

    sel_t sel_d, sel_q;
    logic step;

    always_comb begin
        step  = tick_i && carrier_s_i && !locked_i && !trs_s_i;
        sel_d = sel_q;
        if (step) sel_d = sel_q + SEL_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign sel_o = sel_q;

    // R2
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_q) |-> (sel_q == sel_t'($past(sel_q) + SEL_W'(1))));

    // R4
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!carrier_s_i || locked_i) |=> $stable(sel_q));

endmodule

// File: rtl/std_hunt_ctrl.sv
`timescale 1ns/1ps
module std_hunt_ctrl
    import std_hunt_pkg::*;
#(
    parameter int MISS_W    = 4,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              carrier_i,
    input  logic              trs_valid_i,
    input  logic [MISS_W-1:0] miss_limit_i,
    output logic [1:0]        sel_o
);

    localparam int N_ASYNC = 2;

    logic [N_ASYNC-1:0] async_in, sync_out;
    logic               carrier_s, trs_s, locked;
    sel_t               sel;

    assign async_in = {trs_valid_i, carrier_i};

    std_hunt_sync #(.STAGES(SYNC_STGS), .WIDTH(N_ASYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (async_in),
        .sync_o  (sync_out)
    );

    assign carrier_s = sync_out[0];
    assign trs_s     = sync_out[1];

    std_hunt_lock #(.MISS_W(MISS_W)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .trs_s_i  (trs_s),
        .limit_i  (miss_limit_i),
        .locked_o (locked)
    );

    std_hunt_count u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .carrier_s_i (carrier_s),
        .locked_i    (locked),
        .trs_s_i     (trs_s),
        .sel_o       (sel)
    );

    assign sel_o = sel;

    // R3
    move_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_o) |-> $past(tick_i));

endmodule

// File: tb/std_hunt_ctrl_test.sv
`timescale 1ns/1ps
module std_hunt_ctrl_test;

    localparam int MW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic          carrier_i = 1'b0;
    logic          trs_valid_i = 1'b0;
    logic [MW-1:0] miss_limit_i = '0;
    logic [1:0]    sel_o;

    int errors = 0;
    int checks = 0;
    int es = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    std_hunt_ctrl #(.MISS_W(MW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .carrier_i    (carrier_i),
        .trs_valid_i  (trs_valid_i),
        .miss_limit_i (miss_limit_i),
        .sel_o        (sel_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: sel actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic trs_pulse();
        trs_valid_i = 1'b1;
        @(negedge clk);
        trs_valid_i = 1'b0;
        settle(4);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        settle(2);
        check("R1 during reset", int'(sel_o), 0);
        rst_n = 1'b1;
        settle(2);
        check("R1 after reset", int'(sel_o), 0);

        // R2: hunting with wrap
        carrier_i = 1'b1;
        settle(4);
        for (int n = 1; n <= 9; n++) begin
            ticks(1);
            es = (es + 1) % 4;
            check("R2 step", int'(sel_o), es);
        end

        // R3: no tick, no change
        settle(10);
        check("R3 idle", int'(sel_o), es);

        // R4: carrier absent holds code
        carrier_i = 1'b0;
        settle(4);
        ticks(5);
        check("R4 hold no carrier", int'(sel_o), es);
        carrier_i = 1'b1;
        settle(4);

        // R8: drop carrier with ticks on three consecutive edges -> +2
        carrier_i = 1'b0;
        tick_i = 1'b1;
        settle(3);
        tick_i = 1'b0;
        settle(1);
        es = (es + 2) % 4;
        check("R8 carrier fall latency", int'(sel_o), es);
        settle(3);
        // raise carrier with ticks on three consecutive edges -> +1
        carrier_i = 1'b1;
        tick_i = 1'b1;
        settle(3);
        tick_i = 1'b0;
        settle(1);
        es = (es + 1) % 4;
        check("R8 carrier rise latency", int'(sel_o), es);
        settle(3);

        // R5/R6: lock then release sweep
        for (int lim = 0; lim <= 5; lim++) begin
            for (int k = 0; k <= lim + 2; k++) begin
                int le;
                int mv;
                miss_limit_i = MW'(lim);
                le = (lim == 0) ? 1 : lim;
                trs_pulse();
                ticks(k);
                mv = (k > le) ? (k - le) : 0;
                es = (es + mv) % 4;
                check("R6 release after limit", int'(sel_o), es);
            end
        end

        // R5: ticks while synchronised TRS held high
        trs_valid_i = 1'b1;
        settle(4);
        ticks(4);
        check("R5 no step while TRS high", int'(sel_o), es);
        trs_valid_i = 1'b0;
        settle(4);

        // R7: TRS during lock restarts the miss count
        miss_limit_i = MW'(3);
        trs_pulse();
        ticks(2);
        trs_pulse();
        ticks(2);
        check("R7 restart still locked", int'(sel_o), es);
        ticks(1);
        check("R7 release tick no step", int'(sel_o), es);
        ticks(1);
        es = (es + 1) % 4;
        check("R7 step after release", int'(sel_o), es);

        // R9: misses counted with carrier absent
        miss_limit_i = MW'(2);
        trs_pulse();
        carrier_i = 1'b0;
        settle(4);
        ticks(2);
        check("R9 no step while carrier low", int'(sel_o), es);
        carrier_i = 1'b1;
        settle(4);
        ticks(1);
        es = (es + 1) % 4;
        check("R9 released during carrier loss", int'(sel_o), es);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule